// File: doc/BRIEF.md
# Programmable Watchdog Timer with Interrupt or Reset Routing

The block watches for signs of life from a host processor. Software programs one configuration register with a multiplier, a resolution code and a routing bit. The timeout is the multiplier times the selected resolution, where the resolution is one of 1/16 s, 1/4 s, 1 s or 4 s. That gives timeouts from 62.5 ms up to 31 x 4 s. The time base is a single-cycle pulse from a 32 kHz prescaler, synchronous to `clk`. `BASE_TICKS` of those pulses make one 1/16 s step.

The countdown restarts on any write to the configuration register and on either edge of a kick input. The kick input is synchronised first unless a parameter says it is already synchronous. If the timer runs out, the block sets a watchdog flag and stops until it is restarted. The routing chosen at that moment then decides the output. With interrupt routing, an interrupt line stays high for as long as the flag is set. With reset routing, a reset pulse of fixed length is issued instead. A read strobe for the flags register clears the flag. A multiplier of zero, which is also the state after power-on, disables the timer.

Top module: `wdog_steer`

## Requirements
- R1: After `rst_n` the configuration register is zero, and `wdf_o`, `irq_o` and `wd_rst_o` are low. With no write, no number of ticks ever sets the flag.
- R2: The configuration register has these fields: bits [1:0] are the resolution code, bits [6:2] are the multiplier, and bit 7 is the routing bit. A multiplier of zero disables the timer. Writing zero while the timer is counting cancels the pending timeout.
- R3: The timeout is multiplier x 4^code x `BASE_TICKS` tick pulses, counted from the last restart. `wdf_o` rises at the clock edge that samples the final tick pulse, and not one tick earlier.
- R4: A write to the configuration register restarts the full period, even when the value written is unchanged.
- R5: A rising or a falling edge on `kick_i` restarts the full period within `SYNC_STAGES`+1 clock cycles.
- R6: After a timeout the timer stays stopped. Once the flag is cleared, further ticks do not set it again until the timer is restarted.
- R7: With routing bit 0 at the timeout, `irq_o` rises together with `wdf_o` and stays high while the flag is set.
- R8: With routing bit 1 at the timeout, `wd_rst_o` is high for exactly `RST_LEN` clock cycles, starting together with `wdf_o`, and `irq_o` stays low.
- R9: A `flags_rd_i` strobe clears `wdf_o`, and with it `irq_o`, at the next edge. A timeout in the same cycle as the strobe wins, and the flag stays set.
- R10: The routing is captured at the timeout. A later write changes neither the active `irq_o` nor `wdf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | One-cycle pulse per 32 kHz period |
| kick_i | input | 1 | Host kick; either edge restarts the timer |
| cfg_we_i | input | 1 | Write strobe for the configuration register |
| cfg_wdata_i | input | REG_W | Configuration write data |
| flags_rd_i | input | 1 | Flags-register read strobe; clears the flag |
| wdf_o | output | 1 | Watchdog flag |
| irq_o | output | 1 | Interrupt, active high |
| wd_rst_o | output | 1 | Processor reset pulse, active high |

## Verification
The bench counts ticks to the exact final pulse for every resolution code and for the largest multiplier. A prescaler or divider that is off by one would raise the flag one tick early or one tick late. It restarts the timer part way through by rewriting the same value and by toggling the kick both ways. A design that reloads only on a changed value, or only on one kick edge, would time out early. It makes the final tick coincide with a flag read, which catches a design that gives the clear priority and loses the event. It measures the reset pulse length, checks that an expired timer stays quiet, and checks that a later write does not re-route an active interrupt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic {
      WD_ROUTE_IRQ = 1'b0,
      WD_ROUTE_RST = 1'b1
   } wd_route_e;

   // number of base steps per resolution unit: 2^(code*shift)
   function automatic int unsigned wd_res_scale(input int unsigned code,
                                                input int unsigned shift);
      return 32'd1 << (code * shift);
   endfunction

endpackage

// File: rtl/wdog_kick_edge.sv
module wdog_kick_edge #(
   parameter bit SYNC_KICK   = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic edge_o
);

   initial begin
      assert (!SYNC_KICK || SYNC_STAGES >= 2)
         else $fatal(1, "wdog_kick_edge: SYNC_STAGES must be at least 2");
   end

   logic kick_q;
   logic kick_prev;

   generate
      if (SYNC_KICK) begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], kick_i};
         end
         assign kick_q = chain[SYNC_STAGES-1];
      end else begin : g_direct
         assign kick_q = kick_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kick_prev <= 1'b0;
      else        kick_prev <= kick_q;
   end

   assign edge_o = kick_q ^ kick_prev;

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
   parameter int BASE_TICKS = 2048,
   parameter int RES_W      = 2,
   parameter int RES_SHIFT  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic [RES_W-1:0] res_i,
   output logic             unit_o
);

   localparam int PRE_W   = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1;
   localparam int DIV_RAW = RES_SHIFT * ((1 << RES_W) - 1);
   localparam int DIV_W   = (DIV_RAW > 0) ? DIV_RAW : 1;

   initial begin
      assert (BASE_TICKS >= 1) else $fatal(1, "wdog_timebase: BASE_TICKS < 1");
      assert (RES_W >= 1 && RES_SHIFT >= 0 && DIV_RAW <= 30)
         else $fatal(1, "wdog_timebase: resolution range too wide");
   end

   logic [PRE_W-1:0] pre_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W:0]   div_last;
   logic             step;
   int unsigned      sh_amt;

   always_comb begin
      sh_amt   = int'(res_i) * RES_SHIFT;
      div_last = ((DIV_W+1)'(1) << sh_amt) - (DIV_W+1)'(1);
   end

   assign step   = tick_i && (pre_cnt == PRE_W'(BASE_TICKS - 1));
   assign unit_o = step && (div_cnt == div_last[DIV_W-1:0]) && run_i && !restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
      end else if (restart_i || !run_i) begin
         pre_cnt <= '0;
      end else if (tick_i) begin
         pre_cnt <= step ? '0 : pre_cnt + PRE_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
      end else if (restart_i || !run_i) begin
         div_cnt <= '0;
      end else if (step) begin
         div_cnt <= unit_o ? '0 : div_cnt + DIV_W'(1);
      end
   end

   // R3: a resolution unit only ends on a sampled tick pulse
   a_r3_unit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      unit_o |-> tick_i);

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
   parameter int MULT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload_i,
   input  logic [MULT_W-1:0] mult_i,
   input  logic              unit_i,
   output logic              armed_o,
   output logic              expire_o
);

   initial begin
      assert (MULT_W >= 1) else $fatal(1, "wdog_countdown: MULT_W < 1");
   end

   logic [MULT_W-1:0] remain;

   assign expire_o = unit_i && armed_o && !reload_i && (remain == MULT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain  <= '0;
         armed_o <= 1'b0;
      end else if (reload_i) begin
         remain  <= mult_i;
         armed_o <= (mult_i != '0);
      end else if (unit_i && armed_o) begin
         if (remain == MULT_W'(1)) begin
            armed_o <= 1'b0;
         end
         remain <= remain - MULT_W'(1);
      end
   end

   // R2: loading a zero multiplier leaves nothing to expire
   a_r2_zero_mult_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_i && mult_i == '0) |=> !expire_o);

   // R6: once expired, the counter is disarmed until reloaded
   a_r6_stop_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !reload_i) |=> !armed_o);

endmodule

// File: rtl/wdog_route.sv
module wdog_route
   import wdog_pkg::*;
#(
   parameter int RST_LEN = 64
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      expire_i,
   input  wd_route_e route_i,
   input  logic      flags_rd_i,
   output logic      wdf_o,
   output logic      irq_o,
   output logic      rst_o
);

   localparam int RST_CW = $clog2(RST_LEN + 1);

   initial begin
      assert (RST_LEN >= 1) else $fatal(1, "wdog_route: RST_LEN < 1");
   end

   wd_route_e         route_q;
   logic [RST_CW-1:0] rst_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdf_o   <= 1'b0;
         route_q <= WD_ROUTE_IRQ;
      end else if (expire_i) begin
         wdf_o   <= 1'b1;
         route_q <= route_i;
      end else if (flags_rd_i) begin
         wdf_o   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_cnt <= '0;
      end else if (expire_i && route_i == WD_ROUTE_RST) begin
         rst_cnt <= RST_CW'(RST_LEN);
      end else if (rst_cnt != '0) begin
         rst_cnt <= rst_cnt - RST_CW'(1);
      end
   end

   assign irq_o = wdf_o && (route_q == WD_ROUTE_IRQ);
   assign rst_o = (rst_cnt != '0);

   // R3: the flag only rises after a timeout
   a_r3_flag_from_expire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdf_o) |-> $past(expire_i));

   // R9: a read without a simultaneous timeout clears the flag
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_rd_i && !expire_i) |=> !wdf_o);

   // R8: the reset pulse starts only from a timeout routed to reset
   a_r8_rst_from_expire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_o) |-> $past(expire_i && route_i == WD_ROUTE_RST));

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
   import wdog_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int MULT_W      = 5,
   parameter int RES_W       = 2,
   parameter int RES_SHIFT   = 2,
   parameter int BASE_TICKS  = 2048,
   parameter int RST_LEN     = 64,
   parameter bit SYNC_KICK   = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             kick_i,
   input  logic             cfg_we_i,
   input  logic [REG_W-1:0] cfg_wdata_i,
   input  logic             flags_rd_i,
   output logic             wdf_o,
   output logic             irq_o,
   output logic             wd_rst_o
);

   localparam int RES_LSB   = 0;
   localparam int MULT_LSB  = RES_LSB + RES_W;
   localparam int ROUTE_BIT = MULT_LSB + MULT_W;

   initial begin
      assert (ROUTE_BIT < REG_W)
         else $fatal(1, "wdog_steer: fields do not fit in REG_W");
   end

   logic [RES_W-1:0]  res_q;
   logic [MULT_W-1:0] mult_q;
   wd_route_e         route_q;
   logic              kick_edge;
   logic              reload;
   logic              armed;
   logic              unit;
   logic              expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         mult_q  <= '0;
         route_q <= WD_ROUTE_IRQ;
      end else if (cfg_we_i) begin
         res_q   <= cfg_wdata_i[RES_LSB +: RES_W];
         mult_q  <= cfg_wdata_i[MULT_LSB +: MULT_W];
         route_q <= wd_route_e'(cfg_wdata_i[ROUTE_BIT]);
      end
   end

   // a write uses the new multiplier straight from the bus
   logic [MULT_W-1:0] load_mult;
   assign load_mult = cfg_we_i ? cfg_wdata_i[MULT_LSB +: MULT_W] : mult_q;
   assign reload    = cfg_we_i || kick_edge;

   wdog_kick_edge #(
      .SYNC_KICK  (SYNC_KICK),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_kick (
      .clk   (clk),
      .rst_n (rst_n),
      .kick_i(kick_i),
      .edge_o(kick_edge)
   );

   wdog_timebase #(
      .BASE_TICKS(BASE_TICKS),
      .RES_W     (RES_W),
      .RES_SHIFT (RES_SHIFT)
   ) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (armed),
      .restart_i(reload),
      .tick_i   (tick_i),
      .res_i    (res_q),
      .unit_o   (unit)
   );

   wdog_countdown #(
      .MULT_W(MULT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload_i(reload),
      .mult_i  (load_mult),
      .unit_i  (unit),
      .armed_o (armed),
      .expire_o(expire)
   );

   wdog_route #(
      .RST_LEN(RST_LEN)
   ) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire_i  (expire),
      .route_i   (route_q),
      .flags_rd_i(flags_rd_i),
      .wdf_o     (wdf_o),
      .irq_o     (irq_o),
      .rst_o     (wd_rst_o)
   );

   // R4: a write to the register never coincides with a timeout
   a_r4_write_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we_i |=> !$rose(wdf_o) || !$past(cfg_we_i));

endmodule

// File: tb/tb_wdog_steer.sv
module tb_wdog_steer;

   localparam int BT  = 3;
   localparam int RL  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       kick_i = 1'b0;
   logic       cfg_we_i = 1'b0;
   logic [7:0] cfg_wdata_i = '0;
   logic       flags_rd_i = 1'b0;
   logic       wdf_o, irq_o, wd_rst_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   wdog_steer #(.BASE_TICKS(BT), .RST_LEN(RL)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
      .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .flags_rd_i(flags_rd_i),
      .wdf_o(wdf_o), .irq_o(irq_o), .wd_rst_o(wd_rst_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic wr(input bit route, input int mult, input int res);
      @(negedge clk);
      cfg_we_i    = 1'b1;
      cfg_wdata_i = {route, 5'(mult), 2'(res)};
      @(negedge clk);
      cfg_we_i    = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic rd_flags();
      @(negedge clk); flags_rd_i = 1'b1;
      @(negedge clk); flags_rd_i = 1'b0;
   endtask

   function automatic int period(input int mult, input int res);
      return mult * (1 << (2 * res)) * BT;
   endfunction

   task automatic t_reset();
      chk("R1 wdf after reset", wdf_o, 0);
      chk("R1 irq after reset", irq_o, 0);
      chk("R1 rst after reset", wd_rst_o, 0);
      ticks(200);
      chk("R1 no timeout when unprogrammed", wdf_o, 0);
   endtask

   task automatic t_period(input int mult, input int res);
      int k = period(mult, res);
      wr(1'b0, mult, res);
      ticks(k - 1);
      chk($sformatf("R3 early m%0d c%0d", mult, res), wdf_o, 0);
      ticks(1);
      chk($sformatf("R3 on time m%0d c%0d", mult, res), wdf_o, 1);
      chk("R7 irq with flag", irq_o, 1);
      chk("R8 no reset in irq routing", wd_rst_o, 0);
      rd_flags();
      chk("R9 read clears flag", wdf_o, 0);
      chk("R9 read clears irq", irq_o, 0);
   endtask

   task automatic t_write_reload();
      wr(1'b0, 1, 1);
      ticks(8);
      wr(1'b0, 1, 1);
      ticks(period(1, 1) - 1);
      chk("R4 same-value write restarts", wdf_o, 0);
      ticks(1);
      chk("R4 timeout after rewrite", wdf_o, 1);
      rd_flags();
   endtask

   task automatic t_kick();
      wr(1'b0, 1, 1);
      ticks(8);
      @(negedge clk); kick_i = ~kick_i;
      repeat (5) @(negedge clk);
      ticks(period(1, 1) - 1);
      chk($sformatf("R5 kick edge to %0d restarts", kick_i), wdf_o, 0);
      ticks(1);
      chk("R5 timeout after kick", wdf_o, 1);
      rd_flags();
   endtask

   task automatic t_disable_mid();
      wr(1'b0, 1, 1);
      ticks(8);
      wr(1'b0, 0, 1);
      ticks(100);
      chk("R2 zero multiplier cancels", wdf_o, 0);
   endtask

   task automatic t_stop();
      wr(1'b0, 1, 0);
      ticks(3);
      chk("R6 timeout", wdf_o, 1);
      ticks(50);
      chk("R7 irq held while flag set", irq_o, 1);
      rd_flags();
      ticks(50);
      chk("R6 stays stopped after timeout", wdf_o, 0);
   endtask

   task automatic t_reset_route();
      int hi = 0;
      int irq_hi = 0;
      wr(1'b1, 1, 0);
      ticks(2);
      chk("R8 no pulse before timeout", wd_rst_o, 0);
      ticks(1);
      for (int i = 0; i < RL + 6; i++) begin
         if (wd_rst_o) hi++;
         if (irq_o) irq_hi++;
         @(negedge clk);
      end
      chk("R8 reset pulse length", hi, RL);
      chk("R8 irq quiet in reset routing", irq_hi, 0);
      chk("R8 flag set in reset routing", wdf_o, 1);
      rd_flags();
   endtask

   task automatic t_collide();
      wr(1'b0, 1, 0);
      ticks(2);
      @(negedge clk); tick_i = 1'b1; flags_rd_i = 1'b1;
      @(negedge clk); tick_i = 1'b0; flags_rd_i = 1'b0;
      chk("R9 timeout beats read", wdf_o, 1);
      rd_flags();
      chk("R9 later read clears", wdf_o, 0);
   endtask

   task automatic t_route_latch();
      wr(1'b0, 1, 0);
      ticks(3);
      chk("R10 irq up", irq_o, 1);
      wr(1'b1, 0, 0);
      chk("R10 irq kept after re-route write", irq_o, 1);
      chk("R10 flag kept after write", wdf_o, 1);
      chk("R10 no reset from write", wd_rst_o, 0);
      rd_flags();
      chk("R10 irq clears on read", irq_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period(1, 0);
      t_period(2, 1);
      t_period(1, 2);
      t_period(1, 3);
      t_period(31, 0);
      t_write_reload();
      t_kick();
      t_kick();
      t_disable_mid();
      t_stop();
      t_reset_route();
      t_collide();
      t_route_latch();
      summary();
      $finish;
   end

endmodule